// File: doc/BRIEF.md
# Bidirectional Loadable Counter with Terminal Flag

This block keeps an unsigned count of parameterized width and moves it by one step per enabled clock edge, upward or downward as a direction input selects. The next value comes from one of two dedicated arithmetic paths. One is an incrementer built as a chain of half adders seeded with a one at bit zero. The other adds the all-ones word, which is the two's complement of one. A 2-to-1 selector driven by the direction input picks between them. A synchronous clear and a parallel load override counting, so the block also serves as a timer: hold the enable high to count clock ticks and pulse the clear to restart.

A terminal flag tells the surrounding logic that the count has reached its end for the present direction. Counting up, the end is the all-ones word. Counting down, it is zero. The flag comes straight from the stored count and the direction input, so it answers on the same cycle as the direction is changed and does not depend on the enable.

Top module: `updown_tally`

## Requirements
- R1: While `clr` or `rst` is 1 at a rising clock edge, `count_q` becomes 0 after that edge, whatever the other inputs are.
- R2: With `clr` at 0 and `ld_en` at 1 at an edge, `count_q` becomes `ld_val` after the edge, whatever `cnt_en` and `dir_dn` are.
- R3: With `clr` and `ld_en` at 0, `cnt_en` at 1 and `dir_dn` at 0 (up), `count_q` increases by one at the edge.
- R4: With `clr` and `ld_en` at 0, `cnt_en` at 1 and `dir_dn` at 1 (down), `count_q` decreases by one at the edge.
- R5: With `clr`, `ld_en` and `cnt_en` all at 0, `count_q` keeps its value at the edge, whatever `dir_dn` and `ld_val` are.
- R6: While `dir_dn` is 0, `term_hit` is 1 exactly when every bit of `count_q` is 1.
- R7: While `dir_dn` is 1, `term_hit` is 1 exactly when `count_q` is 0.
- R8: `term_hit` follows R6 and R7 in the same cycle whatever `cnt_en` is, and changes at once when `dir_dn` changes.
- R9: The count wraps modulo 2^WIDTH. Counting up from all ones gives 0, and counting down from 0 gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, same effect as clr |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| cnt_en | input | 1 | Allows a count step when no clear or load is active |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| ld_en | input | 1 | Parallel load enable |
| ld_val | input | WIDTH | Value taken on a load |
| count_q | output | WIDTH | Current count |
| term_hit | output | 1 | Terminal flag for the current direction |

## Verification
The hardest situations to reach are the wrap points and the terminal flag while the enable is low. Reaching them by counting alone would take up to 2^WIDTH cycles for each direction. The bench instead uses a parallel load to place the count on every value of a 4-bit configuration. From each value it applies every combination of clear, load and enable in both directions, and it checks the flag before the edge and the count after it. Long runs that cross all ones upward and zero downward confirm that the wrap happens in the middle of a continuous count as well.

// File: rtl/updown_tally_pkg.sv
package updown_tally_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_STEP  = 2'd3
    } act_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic step;
        dir_e dir;
    } ctrl_t;

    function automatic act_e pick_action(input ctrl_t c);
        if (c.clear)     return ACT_CLEAR;
        else if (c.load) return ACT_LOAD;
        else if (c.step) return ACT_STEP;
        else             return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tally_inc.sv
module tally_inc #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] sum_out
);
    logic [WIDTH:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_half
        assign sum_out[i]  = a_in[i] ^ carry[i];
        assign carry[i+1]  = a_in[i] & carry[i];
    end

    always_comb begin
        if (&a_in) begin
            p_inc_wrap_r9: assert (sum_out == '0);
        end
    end
endmodule

// File: rtl/tally_dec.sv
module tally_dec #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] diff_out
);
    logic [WIDTH:0] carry;

    assign carry[0] = 1'b0;

    // Full adders with the second operand tied to 1 at every bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_full
        assign diff_out[i] = ~(a_in[i] ^ carry[i]);
        assign carry[i+1]  = a_in[i] | carry[i];
    end

    always_comb begin
        if (a_in == '0) begin
            p_dec_wrap_r9: assert (&diff_out);
        end
    end
endmodule

// File: rtl/tally_term.sv
module tally_term
    import updown_tally_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] value,
    input  dir_e             dir,
    output logic             hit
);
    logic all_ones;
    logic all_zero;

    assign all_ones = &value;
    assign all_zero = ~(|value);
    assign hit      = (dir == DIR_DOWN) ? all_zero : all_ones;
endmodule

// File: rtl/updown_tally.sv
module updown_tally
    import updown_tally_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic             dir_dn,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] count_q,
    output logic             term_hit
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctrl_t            ctl;
    act_e             act;
    logic [WIDTH-1:0] up_val;
    logic [WIDTH-1:0] dn_val;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] cnt_r;

    assign ctl.clear = clr | rst;
    assign ctl.load  = ld_en;
    assign ctl.step  = cnt_en;
    assign ctl.dir   = dir_e'(dir_dn);
    assign act       = pick_action(ctl);

    tally_inc #(.WIDTH(WIDTH)) u_inc (.a_in(cnt_r), .sum_out(up_val));
    tally_dec #(.WIDTH(WIDTH)) u_dec (.a_in(cnt_r), .diff_out(dn_val));

    assign step_val = (ctl.dir == DIR_DOWN) ? dn_val : up_val;

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: cnt_r <= '0;
            ACT_LOAD:  cnt_r <= ld_val;
            ACT_STEP:  cnt_r <= step_val;
            default:   cnt_r <= cnt_r;
        endcase
    end

    tally_term #(.WIDTH(WIDTH)) u_term (
        .value (cnt_r),
        .dir   (ctl.dir),
        .hit   (term_hit)
    );

    assign count_q = cnt_r;

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (rst)
        clr |=> count_q == '0);

    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && ld_en) |=> count_q == $past(ld_val));

    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld_en && cnt_en && !dir_dn) |=> count_q == WIDTH'($past(count_q) + 1'b1));

    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld_en && cnt_en && dir_dn) |=> count_q == WIDTH'($past(count_q) - 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld_en && !cnt_en) |=> $stable(count_q));

    p_term_up_r6: assert property (@(posedge clk) disable iff (rst)
        !dir_dn |-> (term_hit == (count_q == ALL_ONES)));

    p_term_down_r7: assert property (@(posedge clk) disable iff (rst)
        dir_dn |-> (term_hit == (count_q == '0)));
endmodule

// File: tb/updown_tally_test.sv
module updown_tally_test;
    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst, clr, cnt_en, dir_dn, ld_en;
    logic [W-1:0] ld_val;
    logic [W-1:0] count_q;
    logic         term_hit;

    int vectors = 0;
    int errors  = 0;
    logic [W-1:0] model;

    always #10 clk = ~clk;

    updown_tally #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .clr(clr), .cnt_en(cnt_en), .dir_dn(dir_dn),
        .ld_en(ld_en), .ld_val(ld_val), .count_q(count_q), .term_hit(term_hit)
    );

    task automatic check_count(input string req, input logic [W-1:0] exp);
        vectors++;
        if (count_q !== exp) begin
            errors++;
            $display("FAIL %s count actual=%0d expected=%0d", req, count_q, exp);
        end
    endtask

    // Inputs change 1 ns after a rising edge; flag checked mid-cycle; count checked after next edge.
    task automatic apply(input logic c, input logic l, input logic e,
                         input logic d, input logic [W-1:0] v);
        string treq;
        string creq;
        logic  texp;
        clr = c; ld_en = l; cnt_en = e; dir_dn = d; ld_val = v;
        #4;
        texp = d ? (model == 0) : (model == W'(N-1));
        treq = !e ? "R8" : (d ? "R7" : "R6");
        vectors++;
        if (term_hit !== texp) begin
            errors++;
            $display("FAIL %s term_hit actual=%b expected=%b", treq, term_hit, texp);
        end
        if (c) begin
            model = 0; creq = "R1";
        end else if (l) begin
            model = v; creq = "R2";
        end else if (e) begin
            if (!d) begin
                creq = (model == W'(N-1)) ? "R9" : "R3";
                model = W'((int'(model) + 1) % N);
            end else begin
                creq = (model == 0) ? "R9" : "R4";
                model = W'((int'(model) + N - 1) % N);
            end
        end else begin
            creq = "R5";
        end
        @(posedge clk);
        #1;
        check_count(creq, model);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog count actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1; clr = 0; cnt_en = 1; dir_dn = 0; ld_en = 1; ld_val = '1;
        model = 0;
        @(posedge clk); @(posedge clk); #1;
        check_count("R1", '0);
        rst = 0;

        // Every start value, both directions, every clear/load/enable mix.
        for (int v = 0; v < N; v++) begin
            for (int d = 0; d < 2; d++) begin
                for (int m = 0; m < 8; m++) begin
                    apply(1'b0, 1'b1, 1'b0, 1'b0, W'(v));
                    apply(m[2], m[1], m[0], d[0], W'(~v));
                end
            end
        end

        // Direction flip with enable low: flag follows direction at once (R8).
        apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
        apply(1'b0, 1'b0, 1'b0, 1'b1, '1);
        apply(1'b0, 1'b0, 1'b0, 1'b0, '1);

        // Continuous runs across the wrap points (R9).
        for (int i = 0; i < 2 * N + 3; i++) apply(1'b0, 1'b0, 1'b1, 1'b0, '0);
        for (int i = 0; i < 2 * N + 5; i++) apply(1'b0, 1'b0, 1'b1, 1'b1, '1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule